// File: doc/BRIEF.md
# Segmented hub address translator

This block relocates the hub memory address a core issues. A request carries an offset, an access kind (instruction fetch, data read or data write) and a segment-select flag. The block picks one of four segment bases (code, data, stack or extra) and adds the base, shifted left by four, to the offset. Each base therefore counts in units of four 32-bit words, and the sum wraps within the physical hub address width. The segment and limit values come from the core's segment register bank, which sits outside this block.

Data and stack writes can be fenced by a power-of-two limit. A write whose physical address is not below the limit loses its write strobe, and a violation flag is raised for that one result instead. An optional dual-window mode splits the data space on one offset bit, so that the upper half of each 64 KiB window maps through the extra segment. The result is registered once and appears one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset, and until the first request has been registered, out_valid, out_we, out_violation, out_kind and out_addr are all zero. With all segment bases zero, the physical address equals the offset.
- R2: A request presented with req_valid high at a rising clock edge gives out_valid high for exactly the next cycle. Its address, kind, strobe and violation appear in that same cycle. out_valid is low in every cycle that follows an edge where req_valid was low. The kind encoding is 0 = fetch, 1 = data read, 2 = data write, and 3 = treated as a data read.
- R3: A fetch (kind 0) always uses the code segment, whatever the flag and the dual-window mode.
- R4: A data read or write with req_alt low uses the data segment when dual-window mode is off. With req_alt high it uses the stack segment.
- R5: out_addr = (base × 16 + offset) modulo 2^PA_W. Any carry out of the sum is dropped.
- R6: With dual_mode high, a data access with req_alt low uses the data segment when offset bit WIN_BIT (15 by default) is 0, and the extra segment when that bit is 1. Higher offset bits do not affect the choice. Stack accesses keep the stack segment.
- R7: When dlim_en is high, a write through the data segment is allowed only if its physical address is below 2^dlim_exp. A blocked write gives out_we = 0 and out_violation = 1. An allowed write gives out_we = 1 and out_violation = 0. An exponent of PA_W or more allows every address.
- R8: When slim_en is high, writes through the stack segment are checked against 2^slim_exp in the same way as R7.
- R9: Reads and fetches never raise out_we or out_violation. Writes through the extra segment are never blocked. A write through a segment whose limit is disabled is never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 read |
| req_alt | input | 1 | Segment-select flag: high selects the stack segment for data |
| req_ofs | input | OFS_W (20) | Hub offset issued by the core |
| dual_mode | input | 1 | Enables the dual data window |
| cseg | input | SEG_W (16) | Code segment base |
| dseg | input | SEG_W (16) | Data segment base |
| sseg | input | SEG_W (16) | Stack segment base |
| eseg | input | SEG_W (16) | Extra segment base |
| dlim_en | input | 1 | Data segment write limit enable |
| dlim_exp | input | EXP_W (5) | Data limit as a power-of-two exponent |
| slim_en | input | 1 | Stack segment write limit enable |
| slim_exp | input | EXP_W (5) | Stack limit as a power-of-two exponent |
| out_valid | output | 1 | Registered result valid |
| out_kind | output | 2 | Kind of the registered access |
| out_addr | output | PA_W (20) | Relocated physical address |
| out_we | output | 1 | Write strobe, dropped if blocked |
| out_violation | output | 1 | One-cycle flag for a blocked write |

## Verification
The bench uses the default parameters: 16-bit segment values, a 20-bit offset and address, and window bit 15. These values put the wrap of base 0xFFFF plus a small offset within reach. They also make limit exponents reachable at both ends, from 0 (only address zero passes) up to 20 (all pass). The dual-window split is tested below and above bit 15, and with an offset that sets a higher bit but keeps bit 15 clear. Limits are tested exactly at and one below each boundary, for both data and stack writes.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_C = 2'd0,
    SEL_D = 2'd1,
    SEL_S = 2'd2,
    SEL_E = 2'd3
  } seg_sel_e;
endpackage

// File: rtl/seg_select.sv
module seg_select
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFS_W   = 20,
  parameter int WIN_BIT = 15
) (
  input  acc_kind_e         kind,
  input  logic              alt,
  input  logic              dual,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [SEG_W-1:0]  cseg,
  input  logic [SEG_W-1:0]  dseg,
  input  logic [SEG_W-1:0]  sseg,
  input  logic [SEG_W-1:0]  eseg,
  output seg_sel_e          sel,
  output logic [SEG_W-1:0]  base
);
  always_comb begin
    if (kind == ACC_FETCH)            sel = SEL_C;
    else if (alt)                     sel = SEL_S;
    else if (dual && ofs[WIN_BIT])    sel = SEL_E;
    else                              sel = SEL_D;
  end

  always_comb begin
    case (sel)
      SEL_C:   base = cseg;
      SEL_D:   base = dseg;
      SEL_S:   base = sseg;
      default: base = eseg;
    endcase
  end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int PA_W  = 20,
  parameter int EXP_W = 5
) (
  input  logic [PA_W-1:0]  phys,
  input  logic             en,
  input  logic [EXP_W-1:0] lim_exp,
  output logic             over
);
  function automatic logic [PA_W-1:0] upper_mask(input logic [EXP_W-1:0] e);
    logic [PA_W-1:0] m;
    for (int i = 0; i < PA_W; i++) m[i] = (EXP_W'(i) >= e);
    return m;
  endfunction

  assign over = en && (|(phys & upper_mask(lim_exp)));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFS_W   = 20,
  parameter int WIN_BIT = 15,
  localparam int PA_W   = SEG_W + 4,
  localparam int EXP_W  = $clog2(PA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_alt,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic              dual_mode,
  input  logic [SEG_W-1:0]  cseg,
  input  logic [SEG_W-1:0]  dseg,
  input  logic [SEG_W-1:0]  sseg,
  input  logic [SEG_W-1:0]  eseg,
  input  logic              dlim_en,
  input  logic [EXP_W-1:0]  dlim_exp,
  input  logic              slim_en,
  input  logic [EXP_W-1:0]  slim_exp,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [PA_W-1:0]   out_addr,
  output logic              out_we,
  output logic              out_violation
);
  function automatic logic [PA_W-1:0] relocate(input logic [SEG_W-1:0] s,
                                               input logic [OFS_W-1:0] o);
    return {s, 4'b0000} + PA_W'(o);
  endfunction

  acc_kind_e        kind_e;
  seg_sel_e         sel;
  logic [SEG_W-1:0] base;
  logic [PA_W-1:0]  phys;
  logic             lim_en;
  logic [EXP_W-1:0] lim_exp;
  logic             lim_over;
  logic             is_write;
  logic             wr_blocked;

  assign kind_e = acc_kind_e'(req_kind);

  seg_select #(.SEG_W(SEG_W), .OFS_W(OFS_W), .WIN_BIT(WIN_BIT)) u_sel (
    .kind(kind_e), .alt(req_alt), .dual(dual_mode), .ofs(req_ofs),
    .cseg(cseg), .dseg(dseg), .sseg(sseg), .eseg(eseg),
    .sel(sel), .base(base)
  );

  assign phys = relocate(base, req_ofs);

  always_comb begin
    case (sel)
      SEL_D:   begin lim_en = dlim_en; lim_exp = dlim_exp; end
      SEL_S:   begin lim_en = slim_en; lim_exp = slim_exp; end
      default: begin lim_en = 1'b0;    lim_exp = '0;       end
    endcase
  end

  seg_limit_chk #(.PA_W(PA_W), .EXP_W(EXP_W)) u_lim (
    .phys(phys), .en(lim_en), .lim_exp(lim_exp), .over(lim_over)
  );

  assign is_write   = (kind_e == ACC_WRITE);
  assign wr_blocked = is_write && lim_over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_kind      <= 2'd0;
      out_addr      <= '0;
      out_we        <= 1'b0;
      out_violation <= 1'b0;
    end else begin
      out_valid     <= req_valid;
      out_we        <= req_valid && is_write && !wr_blocked;
      out_violation <= req_valid && wr_blocked;
      if (req_valid) begin
        out_kind <= req_kind;
        out_addr <= phys;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 20,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [OFS_W-1:0] req_ofs,
  input logic [SEG_W-1:0] cseg,
  input logic             wr_blocked,
  input logic             out_valid,
  input logic [1:0]       out_kind,
  input logic [PA_W-1:0]  out_addr,
  input logic             out_we,
  input logic             out_violation
);
  logic [PA_W-1:0] code_addr;
  assign code_addr = PA_W'(cseg) * PA_W'(16) + PA_W'(req_ofs);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  assert_fetch_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=> (out_addr == $past(code_addr)));
  assert_block_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wr_blocked) |=> (out_violation && !out_we));
  assert_viol_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_violation |-> (out_valid && out_kind == 2'd2 && !out_we));
  assert_read_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'd2) |-> (!out_we && !out_violation));
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_ofs(req_ofs), .cseg(cseg), .wr_blocked(wr_blocked),
  .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr),
  .out_we(out_we), .out_violation(out_violation)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 16;
  localparam int OFS_W = 20;
  localparam int PA_W  = 20;
  localparam int EXP_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic req_alt = 1'b0;
  logic [OFS_W-1:0] req_ofs = '0;
  logic dual_mode = 1'b0;
  logic [SEG_W-1:0] cseg = '0, dseg = '0, sseg = '0, eseg = '0;
  logic dlim_en = 1'b0, slim_en = 1'b0;
  logic [EXP_W-1:0] dlim_exp = '0, slim_exp = '0;
  logic out_valid;
  logic [1:0] out_kind;
  logic [PA_W-1:0] out_addr;
  logic out_we, out_violation;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [PA_W-1:0] addr;
    logic [1:0]      kind;
    logic            we;
    logic            viol;
    string           tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_alt(req_alt), .req_ofs(req_ofs), .dual_mode(dual_mode),
    .cseg(cseg), .dseg(dseg), .sseg(sseg), .eseg(eseg),
    .dlim_en(dlim_en), .dlim_exp(dlim_exp), .slim_en(slim_en), .slim_exp(slim_exp),
    .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr),
    .out_we(out_we), .out_violation(out_violation)
  );

  task automatic drive(input logic [1:0] k, input logic alt,
                       input logic [OFS_W-1:0] o, input string tag);
    exp_t e;
    longint b, p;
    bit lim_on, is_d, is_s;
    int ex;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_alt = alt; req_ofs = o;
    is_d = 0; is_s = 0;
    if (k == 2'd0) b = cseg;
    else if (alt) begin b = sseg; is_s = 1; end
    else if (dual_mode && o[15]) b = eseg;
    else begin b = dseg; is_d = 1; end
    p = (b * 16 + longint'(o)) % (longint'(1) << PA_W);
    lim_on = (is_d && dlim_en) || (is_s && slim_en);
    ex = is_d ? int'(dlim_exp) : int'(slim_exp);
    e.addr = PA_W'(p);
    e.kind = k;
    e.we   = (k == 2'd2) && !(lim_on && p >= (longint'(1) << ex));
    e.viol = (k == 2'd2) && lim_on && p >= (longint'(1) << ex);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic gap();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected out_valid, addr=%h expected no result", out_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (out_addr !== e.addr || out_kind !== e.kind ||
            out_we !== e.we || out_violation !== e.viol) begin
          n_fail++;
          $display("FAIL %s: addr=%h kind=%0d we=%b viol=%b expected addr=%h kind=%0d we=%b viol=%b",
                   e.tag, out_addr, out_kind, out_we, out_violation,
                   e.addr, e.kind, e.we, e.viol);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_violation !== 1'b0 ||
        out_addr !== '0 || out_kind !== 2'd0) begin
      n_fail++;
      $display("FAIL R1: reset outputs v=%b we=%b viol=%b addr=%h kind=%0d expected all zero",
               out_valid, out_we, out_violation, out_addr, out_kind);
    end
    rst_n = 1'b1;

    drive(2'd1, 1'b0, 20'h01234, "R1 identity read");
    drive(2'd2, 1'b1, 20'hABCDE, "R1 identity write");
    gap();

    cseg = 16'h0100; dseg = 16'h0200; sseg = 16'h0300; eseg = 16'h0400;
    drive(2'd0, 1'b0, 20'h00010, "R3 fetch");
    drive(2'd1, 1'b0, 20'h00005, "R4 data read");
    drive(2'd1, 1'b1, 20'h00005, "R4 stack read");
    drive(2'd2, 1'b0, 20'h00006, "R4 data write");
    drive(2'd3, 1'b1, 20'h00007, "R2 kind3 as read");
    gap();
    repeat (2) @(negedge clk);

    dual_mode = 1'b1;
    drive(2'd0, 1'b1, 20'h08000, "R3 fetch dual alt");
    drive(2'd1, 1'b0, 20'h07FFF, "R6 low window");
    drive(2'd1, 1'b0, 20'h08000, "R6 high window");
    drive(2'd2, 1'b1, 20'h08000, "R6 stack kept");
    drive(2'd1, 1'b0, 20'h18000, "R6 upper bits high window");
    drive(2'd1, 1'b0, 20'h10000, "R6 upper bits low window");
    gap();

    dual_mode = 1'b0; dseg = 16'hFFFF;
    drive(2'd1, 1'b0, 20'h00020, "R5 wrap");
    drive(2'd2, 1'b0, 20'hFFFFF, "R5 wrap max");
    gap();

    dseg = 16'h0200; dlim_en = 1'b1; dlim_exp = 5'd14;
    sseg = 16'h0100; slim_en = 1'b1; slim_exp = 5'd13;
    drive(2'd2, 1'b0, 20'h01FFF, "R7 below limit");
    drive(2'd2, 1'b0, 20'h02000, "R7 at limit");
    drive(2'd1, 1'b0, 20'h02000, "R9 read over limit");
    drive(2'd2, 1'b1, 20'h00FFF, "R8 below limit");
    drive(2'd2, 1'b1, 20'h01000, "R8 at limit");
    drive(2'd0, 1'b1, 20'h7F000, "R9 fetch over limit");
    gap();

    dual_mode = 1'b1;
    drive(2'd2, 1'b0, 20'h78000, "R9 extra segment write");
    gap();
    dual_mode = 1'b0; dlim_exp = 5'd20; dseg = 16'hFFFF;
    drive(2'd2, 1'b0, 20'h0000F, "R7 full exponent");
    gap();
    dlim_exp = 5'd0; dseg = 16'h0000;
    drive(2'd2, 1'b0, 20'h00000, "R7 exp0 zero");
    drive(2'd2, 1'b0, 20'h00001, "R7 exp0 one");
    gap();
    slim_en = 1'b0;
    drive(2'd2, 1'b1, 20'hF0000, "R9 limit off");
    gap();

    repeat (4) @(negedge clk);
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule